// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Unit

This block watches one external input per interrupt line, in banks of 32 lines. Each line has its own 4-bit trigger mode that selects rising edge, falling edge, high level, low level or both edges. A line whose condition is seen latches a pending bit. Software clears pending bits by writing ones. Each bank drives one interrupt output, which is high while any line of that bank is both pending and enabled.

Software reaches the block over a plain synchronous register port with byte addresses. A write takes effect on the clock edge that samples it. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read. The register port is a control path and has no back-pressure. An access is always accepted on the edge where its strobe is high.

Each bank's registers occupy a window of `STRIDE` bytes, starting at `BASE` for bank 0. With the defaults these are 0x20 and 0x200. Within a window the layout is as follows:
- words 0 to 3 hold the mode fields;
- word 4 holds the enables;
- word 5 holds the pending bits.

Top module: `eint_ctrl`

## Requirements
- R1: Bank b has four mode registers at `BASE + b*STRIDE + 4*k`, with k from 0 to 3. Line n's mode is held in bits `4*(n%8)+3 : 4*(n%8)` of register k = n/8. All four registers and the enable register read back exactly what was last written to them.
- R2: Mode 0 sets line n's pending bit on a low-to-high change of its input. Mode 1 sets it on a high-to-low change. In both modes the opposite change sets nothing.
- R3: Mode 2 sets the pending bit on every cycle while the input is high. Mode 3 sets it on every cycle while the input is low. After a clear, a level that is still active sets the bit again, and an inactive level sets nothing.
- R4: Mode 4 sets the pending bit on either change of the input.
- R5: Mode values 5 to 15 never set a pending bit, whatever the input does.
- R6: Writing a 1 to a bit of the status register (word 5, bit n for line n) clears that bit. Writing a 0 leaves it unchanged. If a set and a clear fall in the same cycle, the bit stays set. Pending bits change only on a set or on such a write.
- R7: Pending bits latch whether or not the line is enabled. The enable register is word 4, with bit n for line n. `irq_o[b]` is the OR over the lines of bank b of (pending AND enable). It falls only after a register write.
- R8: Each bank's registers sit `STRIDE` (0x20) bytes after the previous bank's registers. An access to one bank never touches another bank.
- R9: Reads return zero and writes change nothing in these cases:
  - an address below `BASE`;
  - an address at or beyond `BASE + NUM_BANKS*STRIDE`;
  - words 6 and 7 of a window;
  - an address whose two low bits are not zero.
- R10: After reset all mode, enable and pending registers read zero and every `irq_o` bit is low.
- R11: An input change driven between clock edges shows on `irq_o` (for an enabled line) after the third rising edge that follows it, and not after the second. Two edges are spent in the synchroniser and one in the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_BANKS*32 | Raw line inputs; bank b line n at bit 32*b+n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid after the edge that samples rd_en |
| irq_o | output | NUM_BANKS | Per-bank interrupt request |

## Verification
The assertions rely on the register port being the only way software reaches the block. They take it that a pending bit or an interrupt output can fall only in the cycle after `wr_en` was high, and that a read above the last bank window is unmapped. They also take the line inputs to be driven clear of the clock edge, so the synchroniser never samples a value that is changing. The bench drives every input, both the bus signals and the line levels, on the falling clock edge. It holds each line level for several cycles before it looks at the result, and it makes every register access through a strobe held for exactly one cycle.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int LINES     = 32;
  localparam int MODE_W    = 4;
  localparam int FLD_PER_W = 32 / MODE_W;
  localparam int CFG_REGS  = LINES / FLD_PER_W;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_ANY  = 4'd4
  } trig_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= raw;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              cur,
  input  logic              prev,
  output logic              hit
);
  always_comb begin
    case (mode)
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      TRIG_HIGH: hit = cur;
      TRIG_LOW:  hit = ~cur;
      TRIG_ANY:  hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/eint_bank.sv
module eint_bank
  import eint_pkg::*;
#(
  parameter int WORD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  cur,
  input  logic [LINES-1:0]  prev,
  input  logic              sel,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [31:0]       wdata,
  output logic [31:0]       rword,
  output logic [LINES-1:0]  pend,
  output logic              irq
);
  localparam int CIDX_W = $clog2(CFG_REGS);
  localparam logic [WORD_W-1:0] W_EN = WORD_W'(CFG_REGS);
  localparam logic [WORD_W-1:0] W_ST = WORD_W'(CFG_REGS + 1);

  logic [CFG_REGS-1:0][31:0] cfg_q;
  logic [LINES-1:0]          en_q;
  logic [LINES-1:0]          st_q;
  logic [LINES-1:0]          hit;
  logic [LINES-1:0]          st_clr;
  logic                      cfg_word;

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      eint_detect u_det (
        .mode (cfg_q[gi / FLD_PER_W][MODE_W*(gi % FLD_PER_W) +: MODE_W]),
        .cur  (cur[gi]),
        .prev (prev[gi]),
        .hit  (hit[gi])
      );
    end
  endgenerate

  assign cfg_word = (word < W_EN);
  assign st_clr   = (sel && wr && word == W_ST) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
      st_q  <= '0;
    end else begin
      if (sel && wr && cfg_word) cfg_q[word[CIDX_W-1:0]] <= wdata;
      if (sel && wr && word == W_EN) en_q <= wdata;
      st_q <= (st_q & ~st_clr) | hit;
    end
  end

  always_comb begin
    rword = '0;
    if (cfg_word)          rword = cfg_q[word[CIDX_W-1:0]];
    else if (word == W_EN) rword = en_q;
    else if (word == W_ST) rword = st_q;
  end

  assign pend = st_q;
  assign irq  = |(st_q & en_q);
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  parameter int BASE      = 'h200,
  parameter int STRIDE    = 'h20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*LINES-1:0] line_i,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [NUM_BANKS-1:0]       irq_o
);
  localparam int STRIDE_SH = $clog2(STRIDE);
  localparam int WORD_W    = STRIDE_SH - 2;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int SPAN      = NUM_BANKS * STRIDE;

  logic [NUM_BANKS*LINES-1:0] cur, prev, pend_all;
  logic [ADDR_W-1:0]          off;
  logic                       in_win;
  logic [BANK_W-1:0]          bank_idx;
  logic [WORD_W-1:0]          word;
  logic [NUM_BANKS-1:0][31:0] rword;
  logic [NUM_BANKS-1:0]       bsel;
  logic [31:0]                rd_next;

  assign off      = addr - ADDR_W'(BASE);
  assign in_win   = (addr >= ADDR_W'(BASE)) && (off < ADDR_W'(SPAN)) && (addr[1:0] == 2'b00);
  assign bank_idx = BANK_W'(off >> STRIDE_SH);
  assign word     = off[STRIDE_SH-1:2];

  eint_sync #(.W(NUM_BANKS*LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (line_i),
    .cur  (cur),
    .prev (prev)
  );

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign bsel[gb] = in_win && (bank_idx == BANK_W'(gb));
      eint_bank #(.WORD_W(WORD_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (cur[gb*LINES +: LINES]),
        .prev (prev[gb*LINES +: LINES]),
        .sel  (bsel[gb]),
        .wr   (wr_en),
        .word (word),
        .wdata(wdata),
        .rword(rword[gb]),
        .pend (pend_all[gb*LINES +: LINES]),
        .irq  (irq_o[gb])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bsel[b]) rd_next = rd_next | rword[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  parameter int BASE      = 'h200,
  parameter int STRIDE    = 'h20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             rdata,
  input logic [NUM_BANKS-1:0]    irq_o,
  input logic [NUM_BANKS*32-1:0] pend_all
);
  localparam int TOP = BASE + NUM_BANKS * STRIDE;

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0));

  // R9
  no_high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ({1'b0, addr} >= (ADDR_W+1)'(TOP))) |=> (rdata == '0));

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_chk
      // R6
      pend_drop_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_all[gb*32 +: 32]) & ~pend_all[gb*32 +: 32])) |-> $past(wr_en));
      // R7
      irq_fall_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o[gb]) |-> $past(wr_en));
      // R7
      irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[gb] |-> (|pend_all[gb*32 +: 32]));
    end
  endgenerate
endmodule

bind eint_ctrl eint_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq_o(irq_o), .pend_all(pend_all)
);

// File: tb/eint_ctrl_tb_top.sv
module eint_ctrl_tb_top;
  localparam int NB = 2;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*32-1:0] lines = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NB-1:0] irq_o;
  int n_tests = 0, n_fail = 0;

  // {mode[3:0], level before, level after, pending expected}
  localparam logic [6:0] VEC [13] = '{
    {4'd0,  1'b0, 1'b1, 1'b1}, {4'd0,  1'b1, 1'b0, 1'b0},
    {4'd1,  1'b1, 1'b0, 1'b1}, {4'd1,  1'b0, 1'b1, 1'b0},
    {4'd2,  1'b0, 1'b1, 1'b1}, {4'd2,  1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 1'b0, 1'b1}, {4'd3,  1'b1, 1'b1, 1'b0},
    {4'd4,  1'b0, 1'b1, 1'b1}, {4'd4,  1'b1, 1'b0, 1'b1},
    {4'd5,  1'b0, 1'b1, 1'b0}, {4'd9,  1'b1, 1'b0, 1'b0},
    {4'd15, 1'b0, 1'b1, 1'b0}
  };

  eint_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] cfg_a(int b, int l);
    return AW'('h200 + b*'h20 + 4*(l/8));
  endfunction
  function automatic logic [AW-1:0] en_a(int b);
    return AW'('h210 + b*'h20);
  endfunction
  function automatic logic [AW-1:0] st_a(int b);
    return AW'('h214 + b*'h20);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R10 reset state
    check("R10 irq", 32'(irq_o), 32'h0);
    rd(cfg_a(0, 0), d);  check("R10 cfg", d, 32'h0);
    rd(cfg_a(1, 31), d); check("R10 cfg", d, 32'h0);
    rd(en_a(1), d);      check("R10 en", d, 32'h0);
    rd(st_a(1), d);      check("R10 st", d, 32'h0);

    // R1 read back of mode and enable registers (reserved codes, no line activity)
    wr(cfg_a(1, 16), 32'hFEDC_BA98);
    rd(cfg_a(1, 16), d); check("R1 cfg readback", d, 32'hFEDC_BA98);
    wr(cfg_a(1, 16), 32'h0);
    // R8 stride: bank 1 enable at 0x230 leaves bank 0 untouched
    wr(en_a(1), 32'hA5A5_0F0F);
    rd(AW'('h230), d);   check("R8 bank1 en", d, 32'hA5A5_0F0F);
    rd(AW'('h210), d);   check("R8 bank0 en", d, 32'h0);
    // R9 unmapped reads and writes
    wr(AW'('h211), 32'hFFFF_FFFF);
    wr(AW'('h218), 32'hFFFF_FFFF);
    wr(AW'('h1FC), 32'hFFFF_FFFF);
    rd(AW'('h210), d);   check("R9 write ignored", d, 32'h0);
    rd(AW'('h200), d);   check("R9 write ignored", d, 32'h0);
    rd(AW'('h218), d);   check("R9 read zero", d, 32'h0);
    rd(AW'('h231), d);   check("R9 unaligned read zero", d, 32'h0);
    rd(AW'('h240), d);   check("R9 beyond banks", d, 32'h0);
    rd(AW'('h100), d);   check("R9 below base", d, 32'h0);
    wr(en_a(1), 32'h0);

    // R11 latency, bank 0 line 5, rising mode, enabled
    wr(en_a(0), 32'h20);
    @(negedge clk); lines[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R11 after two edges", 32'(irq_o), 32'h0);
    @(negedge clk); check("R11 after three edges", 32'(irq_o), 32'h1);

    // R6 write of zero keeps, write of one clears
    wr(st_a(0), 32'h0);
    rd(st_a(0), d);      check("R6 zero write", d, 32'h20);
    wr(st_a(0), 32'h20);
    rd(st_a(0), d);      check("R6 clear", d, 32'h0);
    check("R7 irq drops", 32'(irq_o), 32'h0);

    // R7 latch while disabled
    wr(en_a(0), 32'h0);
    lines[5] = 1'b0; wait_cyc(4);
    lines[5] = 1'b1; wait_cyc(4);
    rd(st_a(0), d);      check("R7 latch disabled", d, 32'h20);
    check("R7 irq masked", 32'(irq_o), 32'h0);
    wr(en_a(0), 32'h20);
    check("R7 irq on enable", 32'(irq_o), 32'h1);

    // R6 set wins over clear: high mode with line held high
    wr(cfg_a(0, 5), 32'h0020_0000);
    wait_cyc(2);
    wr(st_a(0), 32'h20);
    rd(st_a(0), d);      check("R6 set wins", d, 32'h20);
    wr(cfg_a(0, 5), 32'h0);
    lines = '0; wr(en_a(0), 32'h0);
    wait_cyc(4);
    wr(st_a(0), 32'hFFFF_FFFF);

    // Table walk: every mode vector on every line of both banks
    for (int b = 0; b < NB; b++) begin
      for (int l = 0; l < 32; l++) begin
        for (int v = 0; v < 13; v++) begin
          logic [3:0] m;
          logic [31:0] exp_st;
          string tag;
          m = VEC[v][6:3];
          tag = (m < 2) ? "R2" : (m < 4) ? "R3" : (m == 4) ? "R4" : "R5";
          wr(cfg_a(b, l), 32'(m) << (4*(l%8)));
          wr(en_a(b), 32'h1 << l);
          lines[b*32+l] = VEC[v][2];
          wait_cyc(4);
          wr(st_a(b), 32'hFFFF_FFFF);
          lines[b*32+l] = VEC[v][1];
          wait_cyc(4);
          exp_st = 32'(VEC[v][0]) << l;
          check({tag, " irq"}, 32'(irq_o), VEC[v][0] ? (32'h1 << b) : 32'h0);
          rd(st_a(b), d);
          check({tag, " status"}, d, exp_st);
          wr(cfg_a(b, l), 32'h0);
          wr(en_a(b), 32'h0);
          lines = '0;
          wait_cyc(4);
          wr(st_a(b), 32'hFFFF_FFFF);
        end
      end
    end

    finish_run();
  end
endmodule